// File: doc/BRIEF.md
# Byte-Lane Chip-Enable Write Sequencer for Asynchronous SRAM

This block sits between a synchronous host and an asynchronous static RAM with four byte lanes. It takes one write at a time over a valid/ready handshake: an address, a 32-bit word and a 4-bit lane mask. It then plays out a write cycle on the RAM pins in which the per-lane chip enables act as the write strobe. The write enable is pulled low before any lane enable falls and is released only after every lane enable has risen. Because of this, the RAM data outputs stay in high impedance for the whole cycle. The output enable is kept inactive throughout.

All timing limits are parameters in nanoseconds. At elaboration each limit is converted to a clock count by rounding up against the clock-period parameter and then adding one cycle of margin. The write moves through five states: idle, setup (address and write enable driven), strobe (selected lane enables low and data driven), release (lane enables high while write enable is still low) and recover (padding up to the minimum cycle time). The block accepts the next request only when it is back in idle.

Top module: `sram_ce_write_seq`

## Requirements
- R1: After reset, `req_ready` is 1, every bit of `ram_bsel_n` is 1, `ram_we_n` is 1, `ram_oe_n` is 1 and `ram_dq_drive` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for exactly SETUP + STROBE + 1 + RECOVER cycles, after which it returns to 1.
- R3: For a limit of t ns, cyc(t) = ceil(t / CLK_NS) + 1. The phase lengths are:
  - SETUP = cyc(T_ADDR_SETUP_NS).
  - STROBE = the maximum of cyc(T_EN_LOW_NS), cyc(T_DATA_SETUP_NS), cyc(T_ADDR_VALID_NS) − SETUP and cyc(T_WE_TO_EN_NS) − SETUP, with a floor of 1.
  - RECOVER = cyc(T_CYCLE_NS) − SETUP − STROBE − 1, with a floor of 1.
  
  The lane enables stay low for exactly STROBE cycles.
- R4: `ram_we_n` is 0 in the first busy cycle, while all lane enables are still high. It stays 0 in every cycle in which any lane enable is low. It rises only in a cycle after one in which all lane enables are already high.
- R5: Bit i of `ram_bsel_n` selects data bits 8i+7..8i. During the strobe phase, bit i is 0 exactly when bit i of the accepted mask is 1, and all selected lanes fall and rise together.
- R6: `ram_dq_drive` is 1 during the strobe phase and the release cycle only, which is STROBE + 1 cycles per request. While it is 1, `ram_dq_out` equals the accepted word.
- R7: `ram_addr` equals the accepted address in every busy cycle, from setup through recover.
- R8: `ram_oe_n` is 1 at all times.
- R9: A request with mask 4'b0000 asserts no lane enable and changes no RAM byte. It still holds `req_ready` low for the same number of cycles as a normal write.
- R10: Changes on `req_valid`, `req_addr`, `req_data` and `req_mask` while `req_ready` is 0 do not affect the write in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host has a write request |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | 8*LANES | Write data word |
| req_mask | input | LANES | Lanes to write, bit i selects byte i |
| ram_addr | output | ADDR_W | RAM address bus |
| ram_bsel_n | output | LANES | Active-low per-lane chip enables |
| ram_we_n | output | 1 | Active-low RAM write enable |
| ram_oe_n | output | 1 | Active-low RAM output enable, held high |
| ram_dq_out | output | 8*LANES | Data to the RAM data bus |
| ram_dq_drive | output | 1 | Tristate control: 1 drives `ram_dq_out` onto the bus |

## Verification
The bench builds the block with CLK_NS = 10, T_EN_LOW_NS = 25 and T_CYCLE_NS = 80, and keeps the other limits at their defaults. This makes the enable-low limit round up from 2.5 clocks and set a strobe of 4 cycles. It also makes the cycle-time limit force a recover phase of 3 cycles, so both the rounding and the padding paths carry weight. A behavioural RAM in the bench commits a byte only at the end of an overlap of its lane enable and write enable. Lane merges, the empty mask and stimulus that changes while the block is busy can therefore be judged by the stored contents.

// File: rtl/sram_ce_write_seq.sv
`timescale 1ns/1ps
module sram_ce_write_seq #(
  parameter int ADDR_W          = 18,
  parameter int LANES           = 4,
  parameter int CLK_NS          = 10,
  parameter int T_ADDR_SETUP_NS = 0,
  parameter int T_EN_LOW_NS     = 10,
  parameter int T_WE_TO_EN_NS   = 10,
  parameter int T_ADDR_VALID_NS = 12,
  parameter int T_DATA_SETUP_NS = 7,
  parameter int T_CYCLE_NS      = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [8*LANES-1:0]   req_data,
  input  logic [LANES-1:0]     req_mask,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic [LANES-1:0]     ram_bsel_n,
  output logic                 ram_we_n,
  output logic                 ram_oe_n,
  output logic [8*LANES-1:0]   ram_dq_out,
  output logic                 ram_dq_drive
);
  function automatic int to_cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS + 1;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SETUP_CYC   = to_cyc(T_ADDR_SETUP_NS);
  localparam int STROBE_CYC  = max2(1, max2(max2(to_cyc(T_EN_LOW_NS), to_cyc(T_DATA_SETUP_NS)),
                                           max2(to_cyc(T_ADDR_VALID_NS) - SETUP_CYC,
                                                to_cyc(T_WE_TO_EN_NS) - SETUP_CYC)));
  localparam int RECOVER_CYC = max2(1, to_cyc(T_CYCLE_NS) - SETUP_CYC - STROBE_CYC - 1);
  localparam int MAX_CYC     = max2(max2(SETUP_CYC, STROBE_CYC), RECOVER_CYC);
  localparam int CNT_W       = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_RELEASE, S_RECOVER} state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [8*LANES-1:0] data_q;
  logic [LANES-1:0]   mask_q;
  wire                last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state  <= S_SETUP;
          cnt    <= CNT_W'(SETUP_CYC - 1);
          addr_q <= req_addr;
          data_q <= req_data;
          mask_q <= req_mask;
        end
        S_SETUP: if (last) begin
          state <= S_STROBE;
          cnt   <= CNT_W'(STROBE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_STROBE: if (last) begin
          state <= S_RELEASE;
          cnt   <= '0;
        end else cnt <= cnt - 1'b1;
        S_RELEASE: begin
          state <= S_RECOVER;
          cnt   <= CNT_W'(RECOVER_CYC - 1);
        end
        S_RECOVER: if (last) state <= S_IDLE;
                   else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign ram_addr     = addr_q;
  assign ram_bsel_n   = (state == S_STROBE) ? ~mask_q : '1;
  assign ram_we_n     = !(state == S_SETUP || state == S_STROBE || state == S_RELEASE);
  assign ram_oe_n     = 1'b1;
  assign ram_dq_out   = data_q;
  assign ram_dq_drive = (state == S_STROBE || state == S_RELEASE);
endmodule

module sram_ce_write_chk #(
  parameter int ADDR_W      = 18,
  parameter int LANES       = 4,
  parameter int CLK_NS      = 10,
  parameter int T_EN_LOW_NS = 10,
  parameter int T_CYCLE_NS  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [LANES-1:0]  ram_bsel_n,
  input logic              ram_we_n,
  input logic              ram_oe_n,
  input logic              ram_dq_drive
);
  logic [15:0] low_run, busy_run;
  wire any_low = ~&ram_bsel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      busy_run <= '0;
    end else begin
      low_run  <= any_low ? low_run + 1'b1 : '0;
      busy_run <= !req_ready ? busy_run + 1'b1 : '0;
    end
  end

  // R4
  bsel_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> !ram_we_n);
  // R4
  bsel_fall_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(&ram_bsel_n) && any_low) |-> $past(!ram_we_n));
  // R4
  we_rise_after_bsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> $past(&ram_bsel_n));
  // R6
  bsel_drives_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_low |-> ram_dq_drive);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(ram_addr));
  // R8
  oe_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe_n);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_low && low_run != 0) |-> (int'(low_run) * CLK_NS >= T_EN_LOW_NS));
  // R3
  cycle_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && busy_run != 0) |-> (int'(busy_run) * CLK_NS >= T_CYCLE_NS));
endmodule

bind sram_ce_write_seq sram_ce_write_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .CLK_NS(CLK_NS),
  .T_EN_LOW_NS(T_EN_LOW_NS), .T_CYCLE_NS(T_CYCLE_NS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .ram_addr(ram_addr), .ram_bsel_n(ram_bsel_n), .ram_we_n(ram_we_n),
  .ram_oe_n(ram_oe_n), .ram_dq_drive(ram_dq_drive)
);

// File: tb/sram_ce_write_seq_tb.sv
`timescale 1ns/1ps
module sram_ce_write_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int T_EN_LOW = 25;
  localparam int T_CYC    = 80;

  function automatic int cyc(int ns);
    return (ns + CLK_PERIOD - 1) / CLK_PERIOD + 1;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SETUP   = cyc(0);
  localparam int E_STROBE  = mx(1, mx(mx(cyc(T_EN_LOW), cyc(7)), mx(cyc(12) - E_SETUP, cyc(10) - E_SETUP)));
  localparam int E_RECOVER = mx(1, cyc(T_CYC) - E_SETUP - E_STROBE - 1);
  localparam int E_BUSY    = E_SETUP + E_STROBE + 1 + E_RECOVER;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0, ram_addr;
  logic [31:0] req_data = '0, ram_dq_out;
  logic [3:0] req_mask = '0, ram_bsel_n;
  logic ram_we_n, ram_oe_n, ram_dq_drive;

  int n_checks = 0, n_fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ce_write_seq #(.ADDR_W(ADDR_W), .CLK_NS(CLK_PERIOD), .T_EN_LOW_NS(T_EN_LOW), .T_CYCLE_NS(T_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
    .ram_addr(ram_addr), .ram_bsel_n(ram_bsel_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_drive(ram_dq_drive));

  // behavioural RAM: a lane commits at the end of its enable/write-enable overlap
  logic [7:0] mem [16][4];
  logic [7:0] exp_mem [16][4];
  logic [3:0] p_bsel = '1;
  logic p_we = 1'b1;
  logic [31:0] p_dq = '0;
  logic [3:0] p_idx = '0;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++)
      if (!p_bsel[i] && !p_we && (ram_bsel_n[i] || ram_we_n))
        mem[p_idx][i] <= p_dq[8*i +: 8];
    p_bsel <= ram_bsel_n;
    p_we   <= ram_we_n;
    p_dq   <= ram_dq_out;
    p_idx  <= ram_addr[3:0];
  end

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int idx, input bit from_ram);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = from_ram ? mem[idx][i] : exp_mem[idx][i];
    return w;
  endfunction

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] m,
                          input bit scramble, input string tag);
    int busy = 0, strobe = 0, drive = 0;
    bit order_ok = 1, lane_ok = 1, data_ok = 1, addr_ok = 1, oe_ok = 1, first = 1, prev_low = 0;
    @(negedge clk);
    chk(req_ready == 1, tag, "ready before request (R2)", req_ready, 1);
    req_valid = 1; req_addr = a; req_data = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    while (!req_ready && busy < 100) begin
      bit low;
      low = ~&ram_bsel_n;
      busy++;
      if (low) strobe++;
      if (ram_dq_drive) drive++;
      if (first && !(ram_we_n == 0 && &ram_bsel_n)) order_ok = 0;
      if (low && ram_we_n) order_ok = 0;
      if (prev_low && !low && ram_we_n) order_ok = 0;
      if (low && ram_bsel_n != ~m) lane_ok = 0;
      if (low && (!ram_dq_drive || ram_dq_out != d)) data_ok = 0;
      if (ram_addr != a) addr_ok = 0;
      if (!ram_oe_n) oe_ok = 0;
      first = 0; prev_low = low;
      if (scramble) begin
        req_valid = 1; req_addr = ~a; req_data = ~d; req_mask = ~m;
      end
      @(negedge clk);
    end
    req_valid = 0;
    for (int i = 0; i < 4; i++) if (m[i]) exp_mem[a[3:0]][i] = d[8*i +: 8];
    chk(busy == E_BUSY, tag, "busy cycles (R2)", busy, E_BUSY);
    chk(strobe == (m != 0 ? E_STROBE : 0), tag, "strobe cycles (R3/R9)", strobe, (m != 0 ? E_STROBE : 0));
    chk(order_ok, tag, "write-enable ordering (R4)", order_ok, 1);
    chk(lane_ok, tag, "lane enables vs mask (R5)", lane_ok, 1);
    chk(data_ok && drive == E_STROBE + 1, tag, "data drive window (R6)", drive, E_STROBE + 1);
    chk(addr_ok, tag, "address held (R7)", addr_ok, 1);
    chk(oe_ok, tag, "output enable high (R8)", oe_ok, 1);
    chk(ram_we_n && &ram_bsel_n && !ram_dq_drive, tag, "idle pins after write (R4)",
        {ram_we_n, ram_bsel_n, ram_dq_drive}, 6'b111110);
    chk(word(a[3:0], 1) == word(a[3:0], 0), tag, "RAM contents (R5)", word(a[3:0], 1), word(a[3:0], 0));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1 && &ram_bsel_n && ram_we_n && ram_oe_n && !ram_dq_drive, "R1", "reset pins",
        {req_ready, ram_bsel_n, ram_we_n, ram_oe_n, ram_dq_drive}, 8'b11111110);
  endtask

  task automatic t_full;      do_write(18'h00003, 32'hA1B2C3D4, 4'b1111, 0, "R5 full"); endtask
  task automatic t_partial;   do_write(18'h00003, 32'h11223344, 4'b0101, 0, "R5 partial"); endtask
  task automatic t_single;    do_write(18'h10009, 32'hDEADBEEF, 4'b1000, 0, "R5 single"); endtask
  task automatic t_zero_mask; do_write(18'h10009, 32'h55555555, 4'b0000, 0, "R9 empty mask"); endtask
  task automatic t_busy_ignore; do_write(18'h0000C, 32'h0F1E2D3C, 4'b0110, 1, "R10 busy inputs"); endtask
  task automatic t_back_to_back;
    do_write(18'h00005, 32'hCAFEF00D, 4'b1111, 0, "R2 first");
    do_write(18'h00006, 32'h12345678, 4'b0011, 0, "R2 second");
    chk(word(5, 1) == 32'hCAFEF00D, "R2", "first word intact", word(5, 1), 32'hCAFEF00D);
  endtask

  initial begin
    for (int w = 0; w < 16; w++)
      for (int i = 0; i < 4; i++) begin mem[w][i] = 8'h00; exp_mem[w][i] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_full();
    t_partial();
    t_single();
    t_zero_mask();
    t_busy_ignore();
    t_back_to_back();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule